// File: doc/BRIEF.md
# Conversion Result Offset and Gain Corrector

This block sits between a converter's raw result and the result register and corrects every sample for offset and gain error. Each raw sample first has a signed offset added to it. The offset-corrected value is then multiplied by an unsigned fixed-point gain. The product is rounded to an integer and clamped to the range of the active result format.

The correction runs as a fixed-depth pipeline that accepts a new sample on every clock. Only an isolated sample, or the first sample of a stream, shows the full latency. After that, corrected results leave at the same rate as raw samples arrive. The offset, gain and format settings travel down the pipeline with each sample.

When correction is switched off, samples go straight from input to output in the same cycle. A flush input empties the pipeline at once.

Top module: `gain_offset_corrector`

## Requirements
- R1: With `diff_mode` low, `in_data` and `out_data` are unsigned. The result is floor(((in_data + offset) * gain + 1024) / 2048), clamped to 0..4095. `offset` is a 12-bit two's-complement value. `gain` is an unsigned value with 1 integer bit and 11 fraction bits, so 2048 is a gain of 1.0.
- R2: With `diff_mode` high, `in_data` and `out_data` are 12-bit two's complement. The same formula applies, and the result is clamped to -2048..2047.
- R3: Rounding goes to the nearest integer, and an exact half rounds toward positive infinity. For example, +0.5 gives 1, -0.5 gives 0 and 1.5 gives 2.
- R4: With `corr_en` high and no flush, a sample accepted in cycle n gives exactly one `out_valid` pulse, in cycle n+13.
- R5: Samples presented on consecutive cycles give results on consecutive cycles, in the same order.
- R6: The `offset`, `gain` and `diff_mode` values sampled together with `in_valid` are the ones applied to that sample. Changing them in later cycles does not alter results already in flight.
- R7: With `corr_en` low, `out_valid` equals `in_valid` and `out_data` equals `in_data` in the same cycle.
- R8: A cycle with `corr_en` low discards every corrected result still in flight. None of them appears after correction is enabled again.
- R9: In a cycle with `flush` high and `corr_en` high, `out_valid` is low. The sample presented in that cycle is discarded, and so is every sample still in flight.
- R10: After synchronous reset, no corrected result appears until a sample has been accepted and 13 cycles have passed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Discard all samples in flight, including the current one |
| corr_en | input | 1 | Correction enable; low selects the same-cycle bypass |
| diff_mode | input | 1 | Result format for this sample: 0 unsigned, 1 two's complement |
| offset | input | 12 | Signed offset added before the gain |
| gain | input | 12 | Unsigned gain with 11 fraction bits |
| in_valid | input | 1 | Raw sample strobe |
| in_data | input | 12 | Raw sample |
| out_valid | output | 1 | Result strobe |
| out_data | output | 12 | Corrected or bypassed result |

## Verification
The properties assume that reset is high from time zero and that `corr_en`, `flush` and `in_valid` always carry known levels. They also assume that `in_data` is known in every bypass cycle that carries a valid sample. The stimulus meets these assumptions: it drives every input to a defined value before the first edge, changes inputs only on the falling clock, and holds reset for several cycles. The sweeps change the settings on every sample and mix both formats, so a result that picked up a neighbour's settings would show up as a wrong value.

// File: rtl/corr_pkg.sv
package corr_pkg;

    // Sample and setting widths.
    localparam int RAW_W     = 12;
    localparam int OFS_W     = 12;
    localparam int GAIN_W    = 12;
    localparam int GAIN_FRAC = 11;

    // Derived datapath widths.
    localparam int SUM_W     = RAW_W + 2;            // raw + offset, signed, never wraps
    localparam int PROD_W    = SUM_W + GAIN_W + 1;   // signed sum times zero-extended gain
    localparam int HALF_LSB  = 1 << (GAIN_FRAC - 1); // rounding bias

    // Minimum pipeline: add, multiply, round/saturate.
    localparam int MATH_STAGES = 3;

    typedef enum logic {
        FMT_UNSIGNED = 1'b0,
        FMT_SIGNED   = 1'b1
    } fmt_e;

    typedef struct packed {
        logic              vld;
        fmt_e              fmt;
        logic [SUM_W-1:0]  sum;
        logic [GAIN_W-1:0] gain;
    } sum_bus_t;

    typedef struct packed {
        logic              vld;
        fmt_e              fmt;
        logic [PROD_W-1:0] prod;
    } prod_bus_t;

    typedef struct packed {
        logic             vld;
        logic [RAW_W-1:0] data;
    } res_bus_t;

    // Widen a raw code to the sum width according to its format.
    function automatic logic [SUM_W-1:0] widen_raw(input logic [RAW_W-1:0] raw,
                                                   input fmt_e fmt);
        if (fmt == FMT_SIGNED)
            return {{(SUM_W-RAW_W){raw[RAW_W-1]}}, raw};
        return {{(SUM_W-RAW_W){1'b0}}, raw};
    endfunction

    // Sign-extend the offset setting to the sum width.
    function automatic logic [SUM_W-1:0] widen_ofs(input logic [OFS_W-1:0] ofs);
        return {{(SUM_W-OFS_W){ofs[OFS_W-1]}}, ofs};
    endfunction

    // Round half up, then clamp to the range of the format.
    function automatic logic [RAW_W-1:0] round_clamp(input logic [PROD_W-1:0] prod,
                                                     input fmt_e fmt);
        logic signed [PROD_W-1:0] biased;
        int q;
        int lo;
        int hi;
        biased = $signed(prod + PROD_W'(HALF_LSB));
        q      = int'(biased >>> GAIN_FRAC);
        if (fmt == FMT_SIGNED) begin
            lo = -(1 << (RAW_W - 1));
            hi = (1 << (RAW_W - 1)) - 1;
        end else begin
            lo = 0;
            hi = (1 << RAW_W) - 1;
        end
        if (q > hi)
            q = hi;
        else if (q < lo)
            q = lo;
        return q[RAW_W-1:0];
    endfunction

endpackage

// File: rtl/corr_add_stage.sv
module corr_add_stage
    import corr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              kill,
    input  logic              in_vld,
    input  logic [RAW_W-1:0]  raw,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [GAIN_W-1:0] gain,
    input  fmt_e              fmt,
    output sum_bus_t          q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.vld  <= in_vld & ~kill;
            q.fmt  <= fmt;
            q.sum  <= widen_raw(raw, fmt) + widen_ofs(ofs);
            q.gain <= gain;
        end
    end

endmodule

// File: rtl/corr_mul_stage.sv
module corr_mul_stage
    import corr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      kill,
    input  sum_bus_t  d,
    output prod_bus_t q
);

    logic signed [PROD_W-1:0] product;

    // Signed sum times the gain, with the gain taken as a non-negative value.
    assign product = $signed(d.sum) * $signed({1'b0, d.gain});

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.vld  <= d.vld & ~kill;
            q.fmt  <= d.fmt;
            q.prod <= product;
        end
    end

endmodule

// File: rtl/corr_round_stage.sv
module corr_round_stage
    import corr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      kill,
    input  prod_bus_t d,
    output res_bus_t  q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.vld  <= d.vld & ~kill;
            q.data <= round_clamp(d.prod, d.fmt);
        end
    end

endmodule

// File: rtl/corr_delay_line.sv
module corr_delay_line
    import corr_pkg::*;
#(
    parameter int DEPTH = 10
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     kill,
    input  res_bus_t d,
    output res_bus_t q
);

    generate
        if (DEPTH == 0) begin : g_pass
            assign q = d;
        end else begin : g_chain
            res_bus_t stg [DEPTH];
            for (genvar i = 0; i < DEPTH; i++) begin : g_stage
                res_bus_t prev;
                if (i == 0) begin : g_head
                    assign prev = d;
                end else begin : g_link
                    assign prev = stg[i-1];
                end
                always_ff @(posedge clk) begin
                    if (rst) begin
                        stg[i] <= '0;
                    end else begin
                        stg[i].vld  <= prev.vld & ~kill;
                        stg[i].data <= prev.data;
                    end
                end
            end
            assign q = stg[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/gain_offset_corrector.sv
module gain_offset_corrector
    import corr_pkg::*;
#(
    parameter int LATENCY = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              corr_en,
    input  logic              diff_mode,
    input  logic [OFS_W-1:0]  offset,
    input  logic [GAIN_W-1:0] gain,
    input  logic              in_valid,
    input  logic [RAW_W-1:0]  in_data,
    output logic              out_valid,
    output logic [RAW_W-1:0]  out_data
);

    localparam int TAIL_DEPTH = LATENCY - MATH_STAGES;

    logic      kill;
    sum_bus_t  sum_q;
    prod_bus_t prod_q;
    res_bus_t  rnd_q;
    res_bus_t  tail_q;

    // Any cycle with correction off or a flush empties the pipeline.
    assign kill = flush | ~corr_en;

    corr_add_stage u_add (
        .clk    (clk),
        .rst    (rst),
        .kill   (kill),
        .in_vld (in_valid),
        .raw    (in_data),
        .ofs    (offset),
        .gain   (gain),
        .fmt    (fmt_e'(diff_mode)),
        .q      (sum_q)
    );

    corr_mul_stage u_mul (
        .clk  (clk),
        .rst  (rst),
        .kill (kill),
        .d    (sum_q),
        .q    (prod_q)
    );

    corr_round_stage u_rnd (
        .clk  (clk),
        .rst  (rst),
        .kill (kill),
        .d    (prod_q),
        .q    (rnd_q)
    );

    corr_delay_line #(
        .DEPTH (TAIL_DEPTH)
    ) u_tail (
        .clk  (clk),
        .rst  (rst),
        .kill (kill),
        .d    (rnd_q),
        .q    (tail_q)
    );

    // Output select: corrected pipeline output or same-cycle bypass.
    always_comb begin
        if (corr_en) begin
            out_valid = tail_q.vld & ~flush;
            out_data  = tail_q.data;
        end else begin
            out_valid = in_valid;
            out_data  = in_data;
        end
    end

endmodule

// File: rtl/corr_checker.sv
module corr_checker #(
    parameter int LATENCY = 13,
    parameter int DW      = 12
) (
    input logic          clk,
    input logic          rst,
    input logic          flush,
    input logic          corr_en,
    input logic          in_valid,
    input logic [DW-1:0] in_data,
    input logic          out_valid,
    input logic [DW-1:0] out_data
);

    localparam int CW = $clog2(LATENCY + 1);

    // Independent model of when accepted samples are due at the output.
    logic [LATENCY-1:0] due;
    logic [CW-1:0]      since_rst;

    always_ff @(posedge clk) begin
        if (rst || flush || !corr_en)
            due <= '0;
        else
            due <= {due[LATENCY-2:0], in_valid};
    end

    always_ff @(posedge clk) begin
        if (rst)
            since_rst <= '0;
        else if (since_rst != CW'(LATENCY))
            since_rst <= since_rst + 1'b1;
    end

    // R4: a result is present exactly when a sample is due
    p_fixed_latency_r4: assert property (@(posedge clk) disable iff (rst)
        (corr_en && !flush) |-> (out_valid == due[LATENCY-1]));

    // R7: bypass strobe follows the input strobe
    p_bypass_valid_r7: assert property (@(posedge clk) disable iff (rst)
        !corr_en |-> (out_valid == in_valid));

    // R7: bypass data follows the input data
    p_bypass_data_r7: assert property (@(posedge clk) disable iff (rst)
        (!corr_en && in_valid) |-> (out_data == in_data));

    // R9: nothing leaves in a flush cycle
    p_flush_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (corr_en && flush) |-> !out_valid);

    // R9: the cycle after a flush is empty as well
    p_flush_empty_r9: assert property (@(posedge clk) disable iff (rst)
        flush |=> (!corr_en || !out_valid));

    // R10: no corrected result before the pipeline could have filled
    p_reset_empty_r10: assert property (@(posedge clk) disable iff (rst)
        (corr_en && since_rst < CW'(LATENCY)) |-> !out_valid);

endmodule

bind gain_offset_corrector corr_checker #(
    .LATENCY (LATENCY),
    .DW      (corr_pkg::RAW_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .corr_en   (corr_en),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/gain_offset_corrector_tb_top.sv
module gain_offset_corrector_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 13;
    localparam int RING       = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        corr_en = 1'b1;
    logic        diff_mode = 1'b0;
    logic [11:0] offset = '0;
    logic [11:0] gain = 12'd2048;
    logic        in_valid = 1'b0;
    logic [11:0] in_data = '0;
    logic        out_valid;
    logic [11:0] out_data;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    bit          ring_v [RING];
    logic [11:0] ring_d [RING];
    string       ring_t [RING];

    always #(CLK_PERIOD/2) clk = ~clk;

    gain_offset_corrector #(.LATENCY(LAT)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .corr_en   (corr_en),
        .diff_mode (diff_mode),
        .offset    (offset),
        .gain      (gain),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // Expected result from the requirement formula.
    function automatic int expect_val(input int raw, input int ofs, input int g, input bit diff);
        int r;
        longint p;
        longint q;
        r = (diff && raw >= 2048) ? raw - 4096 : raw;
        p = longint'(r + ofs) * longint'(g);
        q = (p + 1024) >>> 11;
        if (diff) begin
            if (q > 2047) q = 2047;
            if (q < -2048) q = -2048;
        end else begin
            if (q > 4095) q = 4095;
            if (q < 0) q = 0;
        end
        return int'(q) & 32'hFFF;
    endfunction

    // One cycle: drive inputs at the falling edge, check the outputs, book the expectation.
    task automatic step(input bit v, input int raw, input int ofs, input int g,
                        input bit diff, input bit en, input bit fl, input string tag);
        int slot;
        @(negedge clk);
        in_valid  = v;
        in_data   = raw[11:0];
        offset    = ofs[11:0];
        gain      = g[11:0];
        diff_mode = diff;
        corr_en   = en;
        flush     = fl;
        #1;
        slot = cyc % RING;
        if (!en) begin
            check(out_valid == v, "R7", "bypass valid", int'(out_valid), int'(v));
            if (v) check(out_data == raw[11:0], "R7", "bypass data", int'(out_data), raw);
        end else if (fl) begin
            check(!out_valid, "R9", "valid during flush", int'(out_valid), 0);
        end else begin
            check(out_valid == ring_v[slot], ring_t[slot], "result valid",
                  int'(out_valid), int'(ring_v[slot]));
            if (ring_v[slot])
                check(out_data == ring_d[slot], ring_t[slot], "result data",
                      int'(out_data), int'(ring_d[slot]));
        end
        ring_v[slot] = 1'b0;
        if (!en || fl) begin
            for (int k = 1; k < LAT; k++) begin
                ring_v[(cyc + k) % RING] = 1'b0;
                ring_t[(cyc + k) % RING] = fl ? "R9" : "R8";
            end
        end
        ring_v[(cyc + LAT) % RING] = v && en && !fl;
        ring_d[(cyc + LAT) % RING] = 12'(expect_val(raw, ofs, g, diff));
        ring_t[(cyc + LAT) % RING] = (v && en && !fl) ? tag : ((!en) ? "R8" : (fl ? "R9" : "R4"));
        cyc++;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 0, 0, 2048, 1'b0, 1'b1, 1'b0, tag);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : stimulus
        int ofs_list [6];
        int gain_list [7];
        ofs_list  = '{-2048, -37, 0, 1, 511, 2047};
        gain_list = '{0, 1024, 1025, 1536, 2048, 3071, 4095};
        for (int i = 0; i < RING; i++) begin
            ring_v[i] = 1'b0;
            ring_d[i] = '0;
            ring_t[i] = "R10";
        end

        // Reset state (R10)
        repeat (3) @(negedge clk);
        #1 check(out_valid == 1'b0, "R10", "valid in reset", int'(out_valid), 0);
        @(negedge clk);
        rst = 1'b0;
        #1 check(out_valid == 1'b0, "R10", "valid after reset", int'(out_valid), 0);
        idle(LAT + 2, "R10");

        // Unsigned sweep, back to back, settings change every sample (R1, R5, R6)
        for (int i = 0; i < 420; i++)
            step(1'b1, (i * 211) % 4096, ofs_list[i % 6], gain_list[(i / 6) % 7],
                 1'b0, 1'b1, 1'b0, "R1,R5,R6");
        idle(LAT + 2, "R5");

        // Signed sweep with formats interleaved (R2, R6)
        for (int i = 0; i < 420; i++)
            step(1'b1, (i * 389 + 7) % 4096, ofs_list[(i + 2) % 6], gain_list[(i / 6) % 7],
                 (i % 5) != 0, 1'b1, 1'b0, "R2,R6");
        idle(LAT + 2, "R2");

        // Clamp corners (R1, R2)
        step(1'b1, 4095, 2047, 4095, 1'b0, 1'b1, 1'b0, "R1 clamp high");
        step(1'b1, 0, -2048, 4095, 1'b0, 1'b1, 1'b0, "R1 clamp low");
        step(1'b1, 2047, 2047, 4095, 1'b1, 1'b1, 1'b0, "R2 clamp high");
        step(1'b1, 2048, -2048, 4095, 1'b1, 1'b1, 1'b0, "R2 clamp low");
        step(1'b1, 4095, 0, 2048, 1'b0, 1'b1, 1'b0, "R1 unity");
        idle(LAT + 2, "R1");

        // Rounding halves (R3): +0.5 -> 1, -0.5 -> 0, 1.5 -> 2, -1.5 -> -1
        step(1'b1, 0, 1, 1024, 1'b0, 1'b1, 1'b0, "R3 plus half");
        step(1'b1, 4095, 0, 1024, 1'b1, 1'b1, 1'b0, "R3 minus half");
        step(1'b1, 3, 0, 1024, 1'b0, 1'b1, 1'b0, "R3 one and half");
        step(1'b1, 4093, 0, 1024, 1'b1, 1'b1, 1'b0, "R3 minus one and half");
        idle(LAT + 2, "R3");

        // Isolated samples show the full latency and only once (R4)
        for (int j = 0; j < 4; j++) begin
            step(1'b1, 100 + j * 900, -5 * j, 1500 + j * 300, j[0], 1'b1, 1'b0, "R4");
            idle(LAT + 4, "R4");
        end

        // Bypass (R7)
        for (int j = 0; j < 24; j++)
            step(j % 3 != 1, (j * 1234) % 4096, 300, 3000, j[0], 1'b0, 1'b0, "R7");
        idle(LAT + 2, "R7");

        // Disable drops in-flight results (R8)
        for (int j = 0; j < 6; j++)
            step(1'b1, 500 + j, 10, 2048, 1'b0, 1'b1, 1'b0, "R8");
        step(1'b0, 0, 0, 2048, 1'b0, 1'b0, 1'b0, "R8");
        idle(LAT + 2, "R8");

        // Flush drops in-flight results and the current sample (R9)
        for (int j = 0; j < 8; j++)
            step(1'b1, 1000 + 17 * j, -3, 2500, 1'b0, 1'b1, 1'b0, "R9");
        step(1'b1, 777, 0, 2048, 1'b0, 1'b1, 1'b1, "R9");
        for (int j = 0; j < 5; j++)
            step(1'b1, 2000 + j, 4, 1800, 1'b0, 1'b1, 1'b0, "R9,R5");
        idle(LAT + 3, "R9");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule